// File: doc/BRIEF.md
# Multi-processor global exclusive monitor

This block is the shared reservation tracker behind load-exclusive / store-exclusive pairs in a system with several processors. It keeps one entry per processor, made of an access state (Open or Exclusive) and an address tag. Every processor has its own request channel that carries an operation and a 32-bit address. A fixed-priority arbiter admits exactly one request per cycle, so the entries only ever change one request at a time. For every store-exclusive that is admitted, the block reports a pass or fail decision on the cycle after acceptance.

The tag is the address with its low 11 bits dropped. A plain store from one processor clears any other processor's reservation on the same tag. A store-exclusive that passes clears the matching reservations of all other processors. Each processor also has a counter that forces a spurious failure on every fifth store-exclusive that would otherwise have passed, which stands in for a reservation lost to a cache eviction. A per-processor remove pin drops a processor's entry and its counter when that processor goes away.

Request channels are valid/ready. A request is taken in the cycle where both valid and ready are high. A processor that has been refused must hold valid, op and addr unchanged until it is taken. The response is a single-cycle pulse with no ready, so the consumer must always be able to accept it.

Top module: `excl_global_monitor`

## Requirements
- R1: After reset every entry is Open and every failure counter is zero, so a store-exclusive issued before any load-exclusive fails.
- R2: Op encoding is 2'b01 load-exclusive, 2'b10 store, 2'b11 store-exclusive, 2'b00 no-op. A load-exclusive sets the requester's entry to Exclusive, with tag addr[31:11].
- R3: The tag ignores addr[10:0]. A store-exclusive whose address differs from the reserved one only in bits 10..0 sees a matching tag. One that differs in bit 11 or above does not, and fails.
- R4: A store-exclusive passes only when the requester's entry is Exclusive with a matching tag and the forced failure is not due. Pass or fail, it leaves the requester's entry Open.
- R5: A plain store makes every other processor's Exclusive entry with the same tag Open. It does not change the requester's own entry, and it leaves entries with other tags untouched.
- R6: A passing store-exclusive makes every other processor's Exclusive entry with the same tag Open.
- R7: Each processor counts its eligible store-exclusives, meaning those with an Exclusive entry and a matching tag. The fifth eligible one since reset, since the last forced failure or since a remove fails, and the count then starts again from zero.
- R8: A pulse on proc_remove[i] makes entry i Open and clears counter i.
- R9: req_ready is high for at most one processor: the lowest-numbered one whose req_valid is high. One request is accepted per cycle.
- R10: One cycle after a store-exclusive is accepted, resp_valid pulses for one cycle, with resp_id set to the requester and resp_pass set to the decision. Other operations give no response.
- R11: A no-op request (2'b00) is accepted but changes no entry and no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PROC | Request valid, one bit per processor |
| req_ready | output | NUM_PROC | Request accepted this cycle, at most one bit set |
| req_op | input | 2*NUM_PROC | Operation per processor, 2 bits each, processor i at [2i+1:2i] |
| req_addr | input | 32*NUM_PROC | Address per processor, processor i at [32i+31:32i] |
| proc_remove | input | NUM_PROC | Drop the processor's entry and counter |
| resp_valid | output | 1 | Store-exclusive decision is valid |
| resp_id | output | log2(NUM_PROC) | Processor that issued the store-exclusive |
| resp_pass | output | 1 | 1 = store-exclusive passed, 0 = failed |

## Verification
The bench builds the block with its defaults: four processors, a tag that starts at bit 11, and a forced failure on every fifth eligible store-exclusive. Four processors are enough to have three of them contending at once for the arbiter. They also let one processor clear a reservation held by another while a third sits on an unrelated tag. Draws from a pool of three tags, each with random low bits, make tag matches frequent. They also send the failure counters through several wrap-arounds and make removes land in the middle of a count.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_LDEX  = 2'b01,
    OP_STORE = 2'b10,
    OP_STEX  = 2'b11
  } mon_op_e;
endpackage

// File: rtl/excl_mon_arb.sv
module excl_mon_arb #(
  parameter int NUM_PROC = 4,
  localparam int ID_W = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
  input  logic [NUM_PROC-1:0] valid_i,
  output logic [NUM_PROC-1:0] grant_o,
  output logic [ID_W-1:0]     idx_o,
  output logic                any_o
);
  // lowest index wins; scan from the top so the last hit is the winner
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = NUM_PROC - 1; i >= 0; i--) begin
      if (valid_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = ID_W'(i);
      end
    end
    any_o = |valid_i;
  end
endmodule

// File: rtl/excl_mon_entry.sv
module excl_mon_entry
  import excl_mon_pkg::*;
#(
  parameter int TAG_W       = 21,
  parameter int FAIL_PERIOD = 5,
  localparam int CNT_W = (FAIL_PERIOD > 1) ? $clog2(FAIL_PERIOD) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             is_req_i,
  input  mon_op_e          op_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             pass_any_i,
  input  logic             remove_i,
  output logic             cand_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FAIL_PERIOD - 1);

  logic             excl_q;
  logic [TAG_W-1:0] tag_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit    = excl_q && (tag_q == tag_i);
  assign cand_o = hit && (cnt_q != LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      excl_q <= 1'b0;
      tag_q  <= '0;
      cnt_q  <= '0;
    end else if (remove_i) begin
      excl_q <= 1'b0;
      cnt_q  <= '0;
    end else if (act_i) begin
      if (is_req_i) begin
        case (op_i)
          OP_LDEX: begin
            excl_q <= 1'b1;
            tag_q  <= tag_i;
          end
          OP_STEX: begin
            excl_q <= 1'b0;
            if (hit) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
          end
          default: ;
        endcase
      end else if (hit && ((op_i == OP_STORE) ||
                           (op_i == OP_STEX && pass_any_i))) begin
        excl_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/excl_global_monitor.sv
module excl_global_monitor
  import excl_mon_pkg::*;
#(
  parameter int NUM_PROC    = 4,
  parameter int ADDR_W      = 32,
  parameter int TAG_LSB     = 11,
  parameter int FAIL_PERIOD = 5,
  localparam int ID_W  = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1,
  localparam int TAG_W = ADDR_W - TAG_LSB
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PROC-1:0]        req_valid,
  output logic [NUM_PROC-1:0]        req_ready,
  input  logic [2*NUM_PROC-1:0]      req_op,
  input  logic [ADDR_W*NUM_PROC-1:0] req_addr,
  input  logic [NUM_PROC-1:0]        proc_remove,
  output logic                       resp_valid,
  output logic [ID_W-1:0]            resp_id,
  output logic                       resp_pass
);
  logic [ID_W-1:0]     gidx;
  logic                gany;
  logic [NUM_PROC-1:0] cand;
  mon_op_e             sel_op;
  logic [TAG_W-1:0]    sel_tag;
  logic                sel_pass;

  excl_mon_arb #(.NUM_PROC(NUM_PROC)) u_arb (
    .valid_i(req_valid),
    .grant_o(req_ready),
    .idx_o  (gidx),
    .any_o  (gany)
  );

  assign sel_op   = mon_op_e'(req_op[gidx*2 +: 2]);
  assign sel_tag  = req_addr[gidx*ADDR_W + TAG_LSB +: TAG_W];
  assign sel_pass = gany && (sel_op == OP_STEX) && cand[gidx];

  for (genvar g = 0; g < NUM_PROC; g++) begin : g_entry
    excl_mon_entry #(.TAG_W(TAG_W), .FAIL_PERIOD(FAIL_PERIOD)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_i     (gany),
      .is_req_i  (req_ready[g]),
      .op_i      (sel_op),
      .tag_i     (sel_tag),
      .pass_any_i(sel_pass),
      .remove_i  (proc_remove[g]),
      .cand_o    (cand[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_id    <= '0;
      resp_pass  <= 1'b0;
    end else begin
      resp_valid <= gany && (sel_op == OP_STEX);
      resp_id    <= gidx;
      resp_pass  <= sel_pass;
    end
  end
endmodule

// File: rtl/excl_mon_checker.sv
module excl_mon_checker #(
  parameter int NUM_PROC = 4,
  localparam int ID_W = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_PROC-1:0]   req_valid,
  input logic [NUM_PROC-1:0]   req_ready,
  input logic [2*NUM_PROC-1:0] req_op,
  input logic                  resp_valid,
  input logic [ID_W-1:0]       resp_id,
  input logic                  resp_pass
);
  logic            stex_acc;
  logic [ID_W-1:0] stex_idx;

  always_comb begin
    stex_acc = 1'b0;
    stex_idx = '0;
    for (int i = 0; i < NUM_PROC; i++) begin
      if (req_ready[i] && req_op[2*i +: 2] == 2'b11) begin
        stex_acc = 1'b1;
        stex_idx = ID_W'(i);
      end
    end
  end

  a_r9_one_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));
  a_r9_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);
  a_r9_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid[0] |-> req_ready[0]);
  a_r9_no_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid != '0) |-> (req_ready != '0));
  a_r10_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    stex_acc |=> (resp_valid && resp_id == $past(stex_idx)));
  a_r10_no_stray_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !stex_acc |=> !resp_valid);
  a_r4_pass_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
    resp_pass |-> resp_valid);
endmodule

bind excl_global_monitor excl_mon_checker #(.NUM_PROC(NUM_PROC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .resp_valid(resp_valid),
  .resp_id   (resp_id),
  .resp_pass (resp_pass)
);

// File: tb/test_excl_global_monitor.sv
module test_excl_global_monitor;
  localparam int NP = 4;
  localparam int AW = 32;
  localparam int FP = 5;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NP-1:0] req_valid = '0;
  logic [NP-1:0] req_ready;
  logic [2*NP-1:0]  req_op = '0;
  logic [AW*NP-1:0] req_addr = '0;
  logic [NP-1:0] proc_remove = '0;
  logic          resp_valid;
  logic [1:0]    resp_id;
  logic          resp_pass;

  int errors = 0;
  int checks = 0;

  bit          m_ex  [NP];
  logic [20:0] m_tag [NP];
  int          m_cnt [NP];

  excl_global_monitor #(.NUM_PROC(NP)) i_excl_global_monitor (.*);

  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [20:0] tag_of(logic [31:0] a);
    return a[31:11];
  endfunction

  // model of the monitor, returns the expected decision for store-exclusive
  function automatic bit model(int id, logic [1:0] op, logic [31:0] a);
    logic [20:0] t = tag_of(a);
    bit elig, pass;
    pass = 0;
    case (op)
      2'b01: begin m_ex[id] = 1; m_tag[id] = t; end
      2'b10: for (int j = 0; j < NP; j++)
               if (j != id && m_ex[j] && m_tag[j] == t) m_ex[j] = 0;
      2'b11: begin
        elig = m_ex[id] && m_tag[id] == t;
        pass = elig && m_cnt[id] != FP - 1;
        if (elig) m_cnt[id] = (m_cnt[id] == FP - 1) ? 0 : m_cnt[id] + 1;
        if (pass)
          for (int j = 0; j < NP; j++)
            if (j != id && m_ex[j] && m_tag[j] == t) m_ex[j] = 0;
        m_ex[id] = 0;
      end
      default: ;
    endcase
    return pass;
  endfunction

  task automatic req(string tag, int id, logic [1:0] op, logic [31:0] a);
    bit exp;
    @(negedge clk);
    req_valid[id] = 1'b1;
    req_op[id*2 +: 2] = op;
    req_addr[id*AW +: AW] = a;
    #1;
    check({tag, "/R9 ready"}, 32'(req_ready), 32'(1 << id));
    exp = model(id, op, a);
    @(negedge clk);
    check({tag, "/R10 resp_valid"}, 32'(resp_valid), 32'(op == 2'b11));
    if (op == 2'b11) begin
      check({tag, "/R10 resp_id"}, 32'(resp_id), 32'(id));
      check({tag, " pass"}, 32'(resp_pass), 32'(exp));
    end
    req_valid[id] = 1'b0;
  endtask

  task automatic remove(int id);
    @(negedge clk);
    proc_remove[id] = 1'b1;
    m_ex[id] = 0;
    m_cnt[id] = 0;
    @(negedge clk);
    proc_remove[id] = 1'b0;
  endtask

  localparam logic [31:0] A = 32'h0001_2000;
  localparam logic [31:0] B = 32'h0004_5800;

  initial begin
    #1500000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [20:0] pool [3];
    bit e1, e2, e3;
    for (int i = 0; i < NP; i++) begin m_ex[i] = 0; m_tag[i] = '0; m_cnt[i] = 0; end
    pool[0] = tag_of(A); pool[1] = tag_of(B); pool[2] = 21'h1F_FFFF;
    repeat (3) @(negedge clk);
    check("R1 reset resp_valid", 32'(resp_valid), 0);
    check("R1 reset ready", 32'(req_ready), 0);
    rst_n = 1;
    req("R1", 0, 2'b11, A);
    req("R2", 0, 2'b01, A);
    req("R2", 0, 2'b11, A);
    req("R4", 0, 2'b11, A);
    req("R3", 1, 2'b01, A | 32'h7FF);
    req("R3 low", 1, 2'b11, A);
    req("R3", 1, 2'b01, A);
    req("R3 bit11", 1, 2'b11, A | 32'h800);
    req("R5", 2, 2'b01, A);
    req("R5", 3, 2'b10, A + 5);
    req("R5 other store", 2, 2'b11, A);
    req("R5", 2, 2'b01, A);
    req("R5", 2, 2'b10, A);
    req("R5 own store", 2, 2'b11, A);
    req("R5", 2, 2'b01, A);
    req("R5", 3, 2'b10, B);
    req("R5 other tag", 2, 2'b11, A);
    req("R6", 0, 2'b01, A);
    req("R6", 1, 2'b01, A);
    req("R6 winner", 0, 2'b11, A);
    req("R6 loser", 1, 2'b11, A);
    remove(3);
    for (int k = 0; k < 11; k++) begin
      req("R7", 3, 2'b01, B);
      req("R7 forced", 3, 2'b11, B);
    end
    req("R8", 2, 2'b01, A);
    remove(2);
    req("R8 removed", 2, 2'b11, A);
    req("R11", 1, 2'b01, B);
    req("R11", 0, 2'b00, B);
    req("R11 noop", 1, 2'b11, B);

    // three processors contend for the arbiter
    req("R9", 1, 2'b01, B);
    req("R9", 2, 2'b01, B);
    req("R9", 3, 2'b01, A);
    @(negedge clk);
    for (int i = 1; i < 4; i++) begin
      req_valid[i] = 1'b1;
      req_op[i*2 +: 2] = 2'b11;
      req_addr[i*AW +: AW] = (i == 3) ? A : B;
    end
    e1 = model(1, 2'b11, B);
    e2 = model(2, 2'b11, B);
    e3 = model(3, 2'b11, A);
    #1 check("R9 first grant", 32'(req_ready), 32'b0010);
    @(negedge clk);
    check("R9 resp id1", 32'(resp_id), 1);
    check("R6 arb pass1", 32'(resp_pass), 32'(e1));
    req_valid[1] = 1'b0;
    #1 check("R9 second grant", 32'(req_ready), 32'b0100);
    @(negedge clk);
    check("R9 resp id2", 32'(resp_id), 2);
    check("R6 arb pass2", 32'(resp_pass), 32'(e2));
    req_valid[2] = 1'b0;
    #1 check("R9 third grant", 32'(req_ready), 32'b1000);
    @(negedge clk);
    check("R9 resp id3", 32'(resp_id), 3);
    check("R4 arb pass3", 32'(resp_pass), 32'(e3));
    req_valid[3] = 1'b0;

    void'($urandom(32'd1234));
    for (int n = 0; n < 600; n++) begin
      int id = $urandom % NP;
      logic [1:0] op = 2'($urandom % 4);
      logic [31:0] a = {pool[$urandom % 3], 11'($urandom)};
      if ($urandom % 16 == 0) remove(id);
      else if ($urandom % 3 == 0) req("R2 rnd", id, 2'b01, a);
      else req("R7 rnd", id, op, a);
    end
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule